// File: doc/BRIEF.md
# Multi-channel latency deskew buffer

This block lines up sample streams from several converter channels whose link and transmitter paths each add a known, different latency. Every channel is written into its own small circular buffer. When a realign strobe arrives, the block takes the per-channel latency values from its configuration inputs and finds the largest one. It then sets each channel's read tap to trail its write pointer by the largest latency minus that channel's latency. The slowest channel passes through with no added delay and the faster ones are held back, so samples taken at the same instant leave together on one clock edge.

A configurable output map sends any source channel to any output slot. A map that is not a permutation is refused. A latency value that the buffers cannot absorb raises an error flag and keeps the outputs invalid until a realign with usable values. A single valid signal covers all output slots. It rises only after every channel has streamed long enough to fill its programmed delay.

Top module: `deskew_aligner`

## Requirements
- R1: After reset, `out_valid` and `cfg_err` are 0, `out_data` is all zero, and the output map is the identity (slot j carries channel j).
- R2: On a clock edge where `realign` is high, the latencies in `lat_cfg` are sampled (channel c at bits c*6 +: 6). From then on, channel c reaches the output delayed by (max latency − its latency) + 1 cycles, so samples of one instant share an output cycle.
- R3: If all `in_valid` bits rise together in the cycle after the realign edge and stay high, `out_valid` first goes high on the edge that samples the (D+1)-th valid input cycle, where D = max − min latency. It then stays high for every following valid input cycle.
- R4: `out_valid` is low on any edge where some channel's `in_valid` was low, or where that channel has not yet seen as many consecutive valid cycles as its delay. A dropped `in_valid` restarts that channel's fill count.
- R5: If any sampled latency exceeds 31 (buffer depth 32 minus one), `cfg_err` is set on the realign edge and `out_valid` stays low. A later realign with all latencies in 0..31 clears `cfg_err`.
- R6: When `map_load` is high and the fields of `map_cfg` (slot j at bits j*2 +: 2) form a permutation, the map is loaded. Output slot j (bits j*16 +: 16 of `out_data`) then carries source channel map[j].
- R7: A `map_load` whose fields repeat an index is ignored, and the previous map stays in force.
- R8: The cycle after a realign edge, `out_valid` is low.
- R9: Latencies of 0 and 31 are both accepted, giving delays of up to 31 cycles on a channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| realign | input | 1 | Strobe: sample latencies and restart alignment |
| lat_cfg | input | 24 | Per-channel latency, 6 bits each |
| map_load | input | 1 | Strobe: load output map |
| map_cfg | input | 8 | Output map, 2-bit source index per slot |
| in_valid | input | 4 | Per-channel input valid |
| in_data | input | 64 | Per-channel 16-bit samples |
| out_valid | output | 1 | Shared valid for all output slots |
| out_data | output | 64 | Aligned, remapped 16-bit samples |
| cfg_err | output | 1 | Latency out of range at last realign |

## Verification
Every input sample is coded with its source channel and its capture instant, so each aligned output word is expected on the edge that samples input cycle k. That word carries instant k − max latency, and the first valid word comes on input cycle D = max − min. The driver computes that expected list before streaming and queues it. The monitor samples on the falling edge after each rising edge and pops one entry per valid output. A valid that comes too early, comes too late, has a gap or outlasts the stream shows up as a mismatch, an empty-queue valid or leftover entries. Flags that are due one edge after a realign or map load are checked on the falling edge that follows.

// File: rtl/deskew_aligner.sv
module deskew_aligner #(
  parameter int NCH   = 4,
  parameter int DW    = 16,
  parameter int DEPTH = 32,
  parameter int LATW  = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 realign,
  input  logic [NCH*LATW-1:0]  lat_cfg,
  input  logic                 map_load,
  input  logic [NCH*$clog2(NCH)-1:0] map_cfg,
  input  logic [NCH-1:0]       in_valid,
  input  logic [NCH*DW-1:0]    in_data,
  output logic                 out_valid,
  output logic [NCH*DW-1:0]    out_data,
  output logic                 cfg_err
);
  localparam int PW   = $clog2(DEPTH);
  localparam int IDXW = $clog2(NCH);

  logic [PW-1:0]        wp;
  logic [LATW-1:0]      lat_max;
  logic                 lat_bad;
  logic                 map_ok;
  logic                 armed;
  logic [NCH*IDXW-1:0]  omap_q;
  logic [NCH-1:0]       ready;
  logic [DW-1:0]        tap [NCH];

  always_comb begin
    lat_max = '0;
    lat_bad = 1'b0;
    for (int c = 0; c < NCH; c++) begin
      if (lat_cfg[c*LATW +: LATW] > lat_max) lat_max = lat_cfg[c*LATW +: LATW];
      if (int'(lat_cfg[c*LATW +: LATW]) > DEPTH - 1) lat_bad = 1'b1;
    end
  end

  always_comb begin
    logic [NCH-1:0] seen;
    seen = '0;
    for (int j = 0; j < NCH; j++)
      if (int'(map_cfg[j*IDXW +: IDXW]) < NCH) seen[map_cfg[j*IDXW +: IDXW]] = 1'b1;
    map_ok = &seen;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) wp <= '0;
    else        wp <= wp + 1'b1;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [DW-1:0] ring [DEPTH];
    logic [PW-1:0] dly;
    logic [PW:0]   fill;
    wire  [DW-1:0] din = in_data[c*DW +: DW];

    always_ff @(posedge clk) ring[wp] <= din;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        dly  <= '0;
        fill <= '0;
      end else begin
        if (realign && !lat_bad) dly <= PW'(lat_max - lat_cfg[c*LATW +: LATW]);
        if (realign || !in_valid[c]) fill <= '0;
        else if (int'(fill) != DEPTH) fill <= fill + 1'b1;
      end
    end

    assign tap[c]   = (dly == '0) ? din : ring[wp - dly];
    assign ready[c] = in_valid[c] && (fill >= {1'b0, dly});
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int j = 0; j < NCH; j++) omap_q[j*IDXW +: IDXW] <= IDXW'(j);
    end else if (map_load && map_ok) begin
      omap_q <= map_cfg;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      cfg_err   <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (realign) begin
        armed   <= !lat_bad;
        cfg_err <= lat_bad;
      end
      out_valid <= !realign && armed && (&ready);
      for (int j = 0; j < NCH; j++)
        out_data[j*DW +: DW] <= tap[omap_q[j*IDXW +: IDXW]];
    end
  end

  a_r8_realign_drops_valid: assert property (@(posedge clk) disable iff (!rst_n)
    realign |=> !out_valid);

  a_r5_err_blocks_valid: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !out_valid);

  a_r5_bad_latency_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (realign && lat_bad) |=> cfg_err);

  a_r4_valid_needs_inputs: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(&in_valid));

  a_r7_bad_map_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (map_load && !map_ok) |=> $stable(omap_q));
endmodule

// File: tb/deskew_aligner_tb.sv
module deskew_aligner_tb;
  localparam int NCH = 4, DW = 16, LATW = 6, IDXW = 2;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                realign = 1'b0;
  logic [NCH*LATW-1:0] lat_cfg = '0;
  logic                map_load = 1'b0;
  logic [NCH*IDXW-1:0] map_cfg = '0;
  logic [NCH-1:0]      in_valid = '0;
  logic [NCH*DW-1:0]   in_data = '0;
  logic                out_valid;
  logic [NCH*DW-1:0]   out_data;
  logic                cfg_err;

  int checks = 0;
  int errors = 0;
  int cur_map [NCH] = '{0, 1, 2, 3};
  logic [NCH*DW-1:0] exp_q [$];

  always #2.5 clk = ~clk;

  deskew_aligner u_dut (
    .clk(clk), .rst_n(rst_n), .realign(realign), .lat_cfg(lat_cfg),
    .map_load(map_load), .map_cfg(map_cfg), .in_valid(in_valid),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data),
    .cfg_err(cfg_err)
  );

  function automatic logic [DW-1:0] word(int inst, int ch);
    return DW'(ch * 4096 + ((inst + 1000) & 4095));
  endfunction

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) check("R4 valid with nothing due", 64'(out_valid), 64'd0);
      else check("R2/R3/R6 aligned word", 64'(out_data), 64'(exp_q.pop_front()));
    end
  end

  task automatic load_map(int m [NCH], bit accept);
    for (int j = 0; j < NCH; j++) map_cfg[j*IDXW +: IDXW] = IDXW'(m[j]);
    map_load = 1'b1;
    step();
    map_load = 1'b0;
    if (accept) cur_map = m;
  endtask

  task automatic run(int lat [NCH], int ncyc, bit push);
    int mx = 0, mn = 1000;
    for (int c = 0; c < NCH; c++) begin
      lat_cfg[c*LATW +: LATW] = LATW'(lat[c]);
      if (lat[c] > mx) mx = lat[c];
      if (lat[c] < mn) mn = lat[c];
    end
    realign = 1'b1;
    step();
    realign = 1'b0;
    if (push)
      for (int k = mx - mn; k < ncyc; k++) begin
        logic [NCH*DW-1:0] v;
        for (int j = 0; j < NCH; j++) v[j*DW +: DW] = word(k - mx, cur_map[j]);
        exp_q.push_back(v);
      end
    for (int k = 0; k < ncyc; k++) begin
      in_valid = '1;
      for (int c = 0; c < NCH; c++) in_data[c*DW +: DW] = word(k - lat[c], c);
      @(negedge clk);
      if (k == 0) check("R8 valid low after realign", 64'(out_valid), 64'd0);
      @(posedge clk); #1;
    end
    in_valid = '0;
    repeat (40) step();
    check("R3/R4 all due words delivered", 64'(exp_q.size()), 64'd0);
    exp_q.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check("watchdog", 64'd1, 64'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 out_valid reset", 64'(out_valid), 64'd0);
    check("R1 cfg_err reset", 64'(cfg_err), 64'd0);
    check("R1 out_data reset", 64'(out_data), 64'd0);
    step();

    run('{3, 7, 0, 12}, 60, 1'b1);          // R2 R3 mixed latencies, identity map (R1)
    run('{5, 5, 5, 5}, 30, 1'b1);           // R3 equal latencies, D = 0
    run('{0, 31, 10, 31}, 80, 1'b1);        // R9 extremes 0 and 31

    lat_cfg = '0;
    run('{40, 3, 3, 3}, 50, 1'b0);          // R5 out-of-range latency
    @(negedge clk);
    check("R5 cfg_err set", 64'(cfg_err), 64'd1);
    run('{2, 9, 4, 1}, 40, 1'b1);           // R5 recovery with good values
    @(negedge clk);
    check("R5 cfg_err cleared", 64'(cfg_err), 64'd0);

    load_map('{2, 0, 3, 1}, 1'b1);          // R6 permutation accepted
    run('{6, 1, 14, 8}, 50, 1'b1);
    load_map('{1, 1, 0, 2}, 1'b0);          // R7 repeated index refused
    run('{4, 0, 2, 11}, 50, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule